// File: doc/BRIEF.md
# Total-Store-Order Store Buffer with Load Forwarding

This block sits between one core and its data cache and gives that core total-store-order semantics. A retiring store goes into a small circular buffer and is acknowledged in the same cycle, so the pipeline never waits for the cache. The buffer writes its entries to the cache through a valid/ready write port. Entries leave in the order they arrived, one per cycle at most.

A load from the core is answered one cycle after it is accepted. If one or more buffered stores target the load's word address, the youngest of them supplies the data. Otherwise the data comes from the cache's combinational read port, even when older stores to other addresses are still waiting. This means a store followed by a load is the only pair whose order can appear swapped.

A request port carries two kinds of ordering operation. A full fence and a locked fetch-and-add both wait until the buffer is empty. The fetch-and-add then reads the word, writes back the sum and returns the old value. While either operation is in progress, new stores, loads and further requests are refused.

Top module: `tso_store_buffer`

## Requirements
- R1: A store is taken when `st_valid` and `st_ready` are both high. `st_ready` is high exactly when the buffer holds fewer than DEPTH entries and no ordering operation is in progress. Taking a store never waits for the cache.
- R2: Cache writes from buffered stores leave in the order the stores were taken, at most one per cycle. While `cw_valid` is high and `cw_ready` is low, `cw_valid`, `cw_addr` and `cw_data` hold steady.
- R3: A load is taken when `ld_valid` and `ld_ready` are both high. `ld_resp_valid` is high exactly one cycle later. If buffered stores to the same address exist, `ld_resp_data` equals the data of the most recently taken one.
- R4: A load whose address matches no buffered store returns `cache_rd_data` as seen in the cycle the load was taken. This holds even while stores to other addresses are still buffered and `cw_ready` is held low.
- R5: For a request with `op_kind` = 0 (fence), the one-cycle `op_done` pulse occurs only after every store taken before the request has been written to the cache.
- R6: For a request with `op_kind` = 1 (fetch-and-add), the block first drains the buffer. It then reads the word at `op_addr` and writes old + `op_operand` (modulo 2^64) to that address on the cache write port. It pulses `op_done` with `op_old` equal to the old word.
- R7: From the cycle a request is taken until the cycle of its `op_done` pulse, `st_ready`, `ld_ready` and `op_ready` are all low.
- R8: After reset the buffer is empty. `cw_valid`, `ld_resp_valid` and `op_done` are low, and `st_ready`, `ld_ready` and `op_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store offered by the core |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | 16 | Store word address |
| st_data | input | 64 | Store data |
| ld_valid | input | 1 | Load offered by the core |
| ld_ready | output | 1 | Load can be taken this cycle |
| ld_addr | input | 16 | Load word address |
| ld_resp_valid | output | 1 | Load answer present |
| ld_resp_data | output | 64 | Load answer data |
| op_valid | input | 1 | Ordering request offered |
| op_ready | output | 1 | Ordering request can be taken |
| op_kind | input | 1 | 0 = fence, 1 = fetch-and-add |
| op_addr | input | 16 | Fetch-and-add word address |
| op_operand | input | 64 | Fetch-and-add addend |
| op_done | output | 1 | One-cycle completion pulse |
| op_old | output | 64 | Word read by the fetch-and-add |
| cache_rd_addr | output | 16 | Cache read address |
| cache_rd_data | input | 64 | Cache read data, same cycle |
| cw_valid | output | 1 | Cache write offered |
| cw_ready | input | 1 | Cache accepts the write |
| cw_addr | output | 16 | Cache write address |
| cw_data | output | 64 | Cache write data |

## Verification
The hardest case to reach is a load that hits several buffered stores to one address while the buffer is close to full and the oldest of those entries is leaving at the same clock edge. Other cases need a fetch-and-add to land on a word that still has pending stores. To reach them, the stimulus uses only eight word addresses and drops the cache's `cw_ready` for long random stretches so the buffer fills. Directed sequences stack three stores on one word before a load, fill the buffer past DEPTH, and issue a wrapping fetch-and-add behind a pending all-ones store.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
    localparam int SB_AW = 16;
    localparam int SB_DW = 64;

    typedef logic [SB_AW-1:0] sb_addr_t;
    typedef logic [SB_DW-1:0] sb_data_t;

    typedef struct packed {
        sb_addr_t addr;
        sb_data_t data;
    } sb_entry_t;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_DRAIN,
        OP_READ,
        OP_WRITE,
        OP_DONE
    } op_state_e;

    typedef enum logic {
        KIND_FENCE = 1'b0,
        KIND_ADD   = 1'b1
    } op_kind_e;

    function automatic sb_data_t rmw_sum(sb_data_t a, sb_data_t b);
        return a + b;
    endfunction
endpackage

// File: rtl/sbuf_fifo.sv
module sbuf_fifo import sbuf_pkg::*; #(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  sb_entry_t     push_entry,
    input  logic          pop,
    output sb_entry_t     head_entry,
    output logic [PW-1:0] head_ptr,
    output logic [CW-1:0] count,
    output sb_entry_t     slots [DEPTH]
);
    logic [PW-1:0] tail_ptr;
    sb_entry_t     mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            head_ptr <= '0;
            tail_ptr <= '0;
            count    <= '0;
        end else begin
            if (push) begin
                mem[tail_ptr] <= push_entry;
                tail_ptr      <= tail_ptr + 1'b1;
            end
            if (pop) head_ptr <= head_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head_entry = mem[head_ptr];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign slots[i] = mem[i];
    end
endmodule

// File: rtl/sbuf_fwd.sv
module sbuf_fwd import sbuf_pkg::*; #(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = PW + 1
) (
    input  sb_entry_t     slots [DEPTH],
    input  logic [PW-1:0] head_ptr,
    input  logic [CW-1:0] count,
    input  sb_addr_t      ld_addr,
    output logic          hit,
    output sb_data_t      hit_data
);
    // age-ordered view: position k = k-th oldest live entry
    logic [PW-1:0] idx   [DEPTH];
    logic [DEPTH-1:0] match;

    for (genvar k = 0; k < DEPTH; k++) begin : g_age
        localparam logic [PW-1:0] OFF = PW'(k);
        localparam logic [CW-1:0] POS = CW'(k);
        assign idx[k]   = head_ptr + OFF;
        assign match[k] = (count > POS) && (slots[idx[k]].addr == ld_addr);
    end

    // later (younger) positions override earlier ones
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (match[k]) begin
                hit      = 1'b1;
                hit_data = slots[idx[k]].data;
            end
        end
    end
endmodule

// File: rtl/sbuf_opseq.sv
module sbuf_opseq import sbuf_pkg::*; (
    input  logic      clk,
    input  logic      rst,
    input  logic      op_valid,
    input  logic      op_kind,
    input  sb_addr_t  op_addr,
    input  sb_data_t  op_operand,
    input  logic      buf_empty,
    input  sb_data_t  rd_data,
    input  logic      wr_ready,
    output logic      op_ready,
    output logic      rd_active,
    output sb_addr_t  rd_addr,
    output logic      wr_valid,
    output sb_entry_t wr_entry,
    output logic      op_done,
    output sb_data_t  op_old
);
    op_state_e state;
    op_kind_e  kind_q;
    sb_addr_t  addr_q;
    sb_data_t  operand_q;
    sb_data_t  old_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= OP_IDLE;
            kind_q    <= KIND_FENCE;
            addr_q    <= '0;
            operand_q <= '0;
            old_q     <= '0;
        end else begin
            case (state)
                OP_IDLE: if (op_valid) begin
                    kind_q    <= op_kind_e'(op_kind);
                    addr_q    <= op_addr;
                    operand_q <= op_operand;
                    old_q     <= '0;
                    state     <= OP_DRAIN;
                end
                OP_DRAIN: if (buf_empty)
                    state <= (kind_q == KIND_ADD) ? OP_READ : OP_DONE;
                OP_READ: begin
                    old_q <= rd_data;
                    state <= OP_WRITE;
                end
                OP_WRITE: if (wr_ready) state <= OP_DONE;
                default:  state <= OP_IDLE;
            endcase
        end
    end

    assign op_ready  = (state == OP_IDLE);
    assign rd_active = (state == OP_READ);
    assign rd_addr   = addr_q;
    assign wr_valid  = (state == OP_WRITE);
    assign wr_entry  = '{addr: addr_q, data: rmw_sum(old_q, operand_q)};
    assign op_done   = (state == OP_DONE);
    assign op_old    = old_q;
endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer import sbuf_pkg::*; #(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = PW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             st_valid,
    output logic             st_ready,
    input  logic [SB_AW-1:0] st_addr,
    input  logic [SB_DW-1:0] st_data,
    input  logic             ld_valid,
    output logic             ld_ready,
    input  logic [SB_AW-1:0] ld_addr,
    output logic             ld_resp_valid,
    output logic [SB_DW-1:0] ld_resp_data,
    input  logic             op_valid,
    output logic             op_ready,
    input  logic             op_kind,
    input  logic [SB_AW-1:0] op_addr,
    input  logic [SB_DW-1:0] op_operand,
    output logic             op_done,
    output logic [SB_DW-1:0] op_old,
    output logic [SB_AW-1:0] cache_rd_addr,
    input  logic [SB_DW-1:0] cache_rd_data,
    output logic             cw_valid,
    input  logic             cw_ready,
    output logic [SB_AW-1:0] cw_addr,
    output logic [SB_DW-1:0] cw_data
);
    sb_entry_t     head_entry;
    sb_entry_t     slots [DEPTH];
    logic [PW-1:0] head_ptr;
    logic [CW-1:0] count;
    logic          push, pop, buf_empty;
    logic          fwd_hit;
    sb_data_t      fwd_data;
    logic          rd_active, rmw_wr_valid;
    sb_addr_t      rmw_rd_addr;
    sb_entry_t     rmw_wr_entry;
    logic          ld_fire;

    assign buf_empty = (count == '0);
    assign st_ready  = (count < CW'(DEPTH)) && op_ready;
    assign ld_ready  = op_ready;
    assign push      = st_valid && st_ready;
    assign pop       = !buf_empty && !rmw_wr_valid && cw_ready;
    assign ld_fire   = ld_valid && ld_ready;

    sbuf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_entry ('{addr: st_addr, data: st_data}),
        .pop        (pop),
        .head_entry (head_entry),
        .head_ptr   (head_ptr),
        .count      (count),
        .slots      (slots)
    );

    sbuf_fwd #(.DEPTH(DEPTH)) u_fwd (
        .slots    (slots),
        .head_ptr (head_ptr),
        .count    (count),
        .ld_addr  (ld_addr),
        .hit      (fwd_hit),
        .hit_data (fwd_data)
    );

    sbuf_opseq u_ops (
        .clk        (clk),
        .rst        (rst),
        .op_valid   (op_valid),
        .op_kind    (op_kind),
        .op_addr    (op_addr),
        .op_operand (op_operand),
        .buf_empty  (buf_empty),
        .rd_data    (cache_rd_data),
        .wr_ready   (cw_ready),
        .op_ready   (op_ready),
        .rd_active  (rd_active),
        .rd_addr    (rmw_rd_addr),
        .wr_valid   (rmw_wr_valid),
        .wr_entry   (rmw_wr_entry),
        .op_done    (op_done),
        .op_old     (op_old)
    );

    // shared cache ports: the atomic only uses them with an empty buffer
    assign cache_rd_addr = rd_active ? rmw_rd_addr : ld_addr;
    assign cw_valid      = rmw_wr_valid || !buf_empty;
    assign cw_addr       = rmw_wr_valid ? rmw_wr_entry.addr : head_entry.addr;
    assign cw_data       = rmw_wr_valid ? rmw_wr_entry.data : head_entry.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_resp_valid <= 1'b0;
            ld_resp_data  <= '0;
        end else begin
            ld_resp_valid <= ld_fire;
            if (ld_fire) ld_resp_data <= fwd_hit ? fwd_data : cache_rd_data;
        end
    end
endmodule

// File: rtl/sbuf_checks.sv
module sbuf_checks import sbuf_pkg::*; #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             st_ready,
    input logic             ld_valid,
    input logic             ld_ready,
    input logic             ld_resp_valid,
    input logic             op_ready,
    input logic             op_done,
    input logic             cw_valid,
    input logic             cw_ready,
    input logic [SB_AW-1:0] cw_addr,
    input logic [SB_DW-1:0] cw_data,
    input logic [CW-1:0]    count
);
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    p_full_blocks_r1: assert property (@(posedge clk) disable iff (rst)
        (count == CW'(DEPTH)) |-> !st_ready);

    p_write_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (cw_valid && !cw_ready) |=> (cw_valid && $stable(cw_addr) && $stable(cw_data)));

    p_resp_next_r3: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && ld_ready) |=> ld_resp_valid);

    p_resp_only_r3: assert property (@(posedge clk) disable iff (rst)
        !(ld_valid && ld_ready) |=> !ld_resp_valid);

    p_done_empty_r5: assert property (@(posedge clk) disable iff (rst)
        op_done |-> (count == '0));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        op_done |=> !op_done);

    p_busy_holds_r7: assert property (@(posedge clk) disable iff (rst)
        !op_ready |-> (!st_ready && !ld_ready));

    p_reset_state_r8: assert property (@(posedge clk)
        rst |=> (count == '0 && !ld_resp_valid && !op_done && op_ready));
endmodule

bind tso_store_buffer sbuf_checks #(.DEPTH(DEPTH)) u_checks (.*);

// File: tb/tso_store_buffer_test.sv
module tso_store_buffer_test;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_valid = 0, ld_valid = 0, op_valid = 0, op_kind = 0, cw_ready = 0;
    logic [15:0] st_addr = 0, ld_addr = 0, op_addr = 0;
    logic [63:0] st_data = 0, op_operand = 0;
    logic        st_ready, ld_ready, ld_resp_valid, op_ready, op_done, cw_valid;
    logic [63:0] ld_resp_data, op_old, cw_data, cache_rd_data;
    logic [15:0] cache_rd_addr, cw_addr;

    logic [63:0] cmem [16];
    logic [63:0] arch [16];
    logic [79:0] q [$];

    int n_tests = 0, n_fail = 0;
    bit busy = 0, busy_add = 0, rmw_seen = 0;
    logic [63:0] exp_old, exp_new;
    logic [15:0] exp_op_addr;
    bit lr_pend = 0;
    logic [63:0] lr_exp;
    string lr_tag;
    bit wr_pend;
    logic [15:0] wr_a;
    logic [63:0] wr_d;

    always #10 clk = ~clk;   // 50 MHz

    assign cache_rd_data = cmem[cache_rd_addr[3:0]];

    tso_store_buffer #(.DEPTH(DEPTH)) uut (.*);

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit in_queue(logic [15:0] a);
        foreach (q[i]) if (q[i][79:64] == a) return 1;
        return 0;
    endfunction

    function automatic bit exp_st_ready();
        return (q.size() < DEPTH) && !busy;
    endfunction

    // one clock: inputs already driven; sample mid-cycle, then step past the edge
    task automatic cycle();
        #8;
        if (lr_pend) begin
            chk(ld_resp_valid == 1'b1, "R3 resp valid", 64'(ld_resp_valid), 1);
            chk(ld_resp_data == lr_exp, lr_tag, ld_resp_data, lr_exp);
        end else chk(ld_resp_valid == 1'b0, "R3 no resp", 64'(ld_resp_valid), 0);
        chk(st_ready == exp_st_ready(), "R1 st_ready", 64'(st_ready), 64'(exp_st_ready()));
        chk(ld_ready == !busy, "R7 ld_ready", 64'(ld_ready), 64'(!busy));
        chk(op_ready == !busy, "R7 op_ready", 64'(op_ready), 64'(!busy));
        wr_pend = 0;
        if (cw_valid && cw_ready) begin
            wr_pend = 1; wr_a = cw_addr; wr_d = cw_data;
            if (q.size() > 0) begin
                chk(cw_addr == q[0][79:64], "R2 write addr order", 64'(cw_addr), 64'(q[0][79:64]));
                chk(cw_data == q[0][63:0], "R2 write data order", cw_data, q[0][63:0]);
                void'(q.pop_front());
            end else if (busy && busy_add) begin
                chk(cw_addr == exp_op_addr, "R6 rmw addr", 64'(cw_addr), 64'(exp_op_addr));
                chk(cw_data == exp_new, "R6 rmw sum", cw_data, exp_new);
                rmw_seen = 1;
            end else chk(0, "R2 unexpected write", 64'(cw_addr), 0);
        end
        if (op_done) begin
            chk(busy, "R5 done without request", 1, 64'(busy));
            chk(q.size() == 0, "R5 fence before drain", 64'(q.size()), 0);
            if (busy_add) begin
                chk(rmw_seen, "R6 rmw write missing", 64'(rmw_seen), 1);
                chk(op_old == exp_old, "R6 old value", op_old, exp_old);
            end
            busy = 0;
        end
        lr_pend = ld_valid && ld_ready;
        if (lr_pend) begin
            lr_exp = arch[ld_addr[3:0]];
            lr_tag = in_queue(ld_addr) ? "R3 forward youngest" : "R4 cache bypass";
        end
        if (st_valid && st_ready) begin
            q.push_back({st_addr, st_data});
            arch[st_addr[3:0]] = st_data;
        end
        if (op_valid && op_ready) begin
            busy = 1; busy_add = op_kind; rmw_seen = 0;
            if (op_kind) begin
                exp_op_addr = op_addr;
                exp_old = arch[op_addr[3:0]];
                exp_new = exp_old + op_operand;
                arch[op_addr[3:0]] = exp_new;
            end
        end
        @(posedge clk);
        if (wr_pend) cmem[wr_a[3:0]] = wr_d;
        #1;
    endtask

    task automatic idle_in();
        st_valid = 0; ld_valid = 0; op_valid = 0;
    endtask

    task automatic do_store(logic [15:0] a, logic [63:0] d);
        idle_in(); st_valid = 1; st_addr = a; st_data = d; cycle(); idle_in();
    endtask

    task automatic do_load(logic [15:0] a);
        idle_in(); ld_valid = 1; ld_addr = a; cycle(); idle_in(); cycle();
    endtask

    task automatic do_op(bit k, logic [15:0] a, logic [63:0] v);
        idle_in(); op_valid = 1; op_kind = k; op_addr = a; op_operand = v; cycle(); idle_in();
        for (int i = 0; i < 100 && busy; i++) cycle();
        chk(!busy, "R5 request never completed", 64'(busy), 0);
    endtask

    initial begin
        #(20 * 190000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            cmem[i] = 64'h1000 + 64'(i);
            arch[i] = 64'h1000 + 64'(i);
        end
        repeat (3) @(posedge clk);
        #1 rst = 0;
        #8;
        // R8 reset state
        chk(st_ready && ld_ready && op_ready, "R8 readies after reset", {st_ready, ld_ready, op_ready}, 3'b111);
        chk(!cw_valid && !ld_resp_valid && !op_done, "R8 outputs idle after reset",
            {cw_valid, ld_resp_valid, op_done}, 0);
        @(posedge clk); #1;

        // R4: stores stuck in buffer, load to another address reads cache
        cw_ready = 0;
        do_store(16'd1, 64'hAAAA);
        do_load(16'd2);
        // R3: three stores to one word, youngest wins
        do_store(16'd3, 64'h11); do_store(16'd3, 64'h22); do_store(16'd3, 64'h33);
        do_load(16'd3);
        // R1: fill past DEPTH with the write port stalled
        for (int i = 0; i < DEPTH + 2; i++) do_store(16'(i % 8), 64'(i) << 8);
        do_load(16'd3);
        // R5: fence behind a full buffer
        idle_in(); op_valid = 1; op_kind = 0; cycle(); idle_in();
        repeat (4) cycle();
        cw_ready = 1;
        for (int i = 0; i < 100 && busy; i++) cycle();
        // R6: wrapping fetch-and-add behind a pending all-ones store
        cw_ready = 0;
        do_store(16'd5, 64'hFFFF_FFFF_FFFF_FFFF);
        cw_ready = 1;
        do_op(1, 16'd5, 64'd2);
        do_load(16'd5);

        // random mix, fixed seed
        void'($urandom(32'd2024));
        for (int c = 0; c < 4000; c++) begin
            idle_in();
            cw_ready = ($urandom % 100) < ((c / 400) % 2 ? 20 : 70);
            if ($urandom % 100 < 45) begin
                st_valid = 1; st_addr = 16'($urandom % 8);
                st_data = {$urandom, $urandom};
            end
            if ($urandom % 100 < 35) begin
                ld_valid = 1; ld_addr = 16'($urandom % 8);
            end
            if (!busy && $urandom % 100 < 3) begin
                op_valid = 1; op_kind = 1'($urandom % 2);
                op_addr = 16'($urandom % 8); op_operand = {$urandom, $urandom};
            end
            cycle();
        end
        idle_in(); cw_ready = 1;
        for (int i = 0; i < 200 && (busy || q.size() > 0 || lr_pend); i++) cycle();
        chk(q.size() == 0, "R2 buffer drained at end", 64'(q.size()), 0);
        for (int i = 0; i < 8; i++)
            chk(cmem[i] == arch[i], "R2 final cache contents", cmem[i], arch[i]);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule